// File: doc/BRIEF.md
# Stream-ID Routed Packet Switch

This block forwards packets from a set of ingress streams to a set of egress streams. Each packet's first beat carries a 32-bit stream identifier in its low data bits. The identifier holds four byte-wide fields. The switch reads the destination network byte and the destination host byte from it, then looks the destination up in one of two programmable tables. The first beat of a packet is marked by the boundary after a previous last beat, or by reset. The host table is used when the destination network matches a programmable local network address. Every other destination goes through the network table. The selected egress port then receives the whole packet, from the first beat through the beat flagged last.

All stream interfaces use valid/ready handshakes. A beat moves when valid and ready are both high at a rising clock edge. An ingress must hold its beat stable while its ready is low. An egress can stall the switch at any time by dropping ready, and that stall passes straight back to the ingress that owns the egress. Each egress port has its own round-robin arbiter, which picks among the ingress ports requesting it. A grant is made one clock after an idle egress sees a request, and it is held until the last beat of that packet has moved. The two tables and the local address are written through a plain strobe/address/data settings port. Keeping the tables consistent is the job of software.

Top module: `pkt_switch`

## Requirements
- R1: In the first beat of a packet, data bits [31:0] carry the stream identifier. Only the destination network, bits [15:8], and the destination host, bits [7:0], affect routing. Bits [31:16] and all data above bit 31 are ignored for routing.
- R2: A settings write takes effect when `cfg_wr` is high at a clock edge. Address 0..255 writes network-table entry `addr[7:0]`. Address 256..511 writes host-table entry `addr[7:0]`. Address 512 writes the local network address from `cfg_wdata[7:0]`. Any other address changes nothing. A table entry keeps the low log2(egress count) bits of `cfg_wdata`, so with two egress ports only bit 0 selects the port.
- R3: A destination network equal to the local address routes by the host-table entry of the destination host. Any other destination network routes by the network-table entry of that network.
- R4: Reset clears both tables and the local address to zero, so every packet goes to egress 0 until the tables are written. Right after reset, all `eg_valid` and `in_ready` outputs are low.
- R5: The route of a packet is fixed in the first cycle its first beat is presented. It holds until the last beat is accepted. Table writes made in between affect only later packets.
- R6: Once an egress carries the first beat of a packet, it carries only that packet's beats until the beat marked last. Packets never interleave on an egress.
- R7: Packets from one ingress to one egress leave in the order they arrived, with every beat's data and last flag unchanged. This holds while other ingress ports share the same egress.
- R8: When several ingress ports contend for one egress, grants rotate round-robin, starting after the previous winner, and change only at packet boundaries.
- R9: `in_ready` of an ingress is high only while its packet holds the grant of its egress and that egress's `eg_ready` is high. A granted egress presents `eg_valid` exactly when its owner presents `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Settings write strobe |
| cfg_addr | input | 10 | Settings address |
| cfg_wdata | input | 32 | Settings write data |
| in_valid | input | N_IN | Ingress beat valid, one bit per port |
| in_ready | output | N_IN | Ingress beat accepted |
| in_data | input | N_IN*DATA_W | Ingress beat data, port i at [i*DATA_W +: DATA_W] |
| in_last | input | N_IN | Ingress last beat of packet |
| eg_valid | output | N_OUT | Egress beat valid |
| eg_ready | input | N_OUT | Egress sink ready |
| eg_data | output | N_OUT*DATA_W | Egress beat data, port j at [j*DATA_W +: DATA_W] |
| eg_last | output | N_OUT | Egress last beat of packet |

## Verification
On every cycle the assertions check several grant rules. A grant stays with one ingress until its last beat has moved. A granted ingress is in fact routed to that egress. No ingress is owned by two egress ports at once. A ready is never given without a grant. An ingress's route stays frozen while its packet is in flight. The bench's reference model covers what only scenarios can show. It checks that table lookups send each identifier to the right port through the local-versus-remote choice, and that packet order and content survive random egress stalls. It also checks that contention alternates between ingress ports, and that a table write during a stalled packet leaves that packet's route unchanged.

// File: rtl/sw_pkg.sv
package sw_pkg;

  localparam int SID_W      = 32;
  localparam int FIELD_W    = 8;
  localparam int DNET_LSB   = 8;
  localparam int DHOST_LSB  = 0;
  localparam int TBL_DEPTH  = 1 << FIELD_W;
  localparam int CFG_AW     = 10;
  localparam int CFG_DW     = 32;

  localparam logic [CFG_AW-1:0] LOCAL_REG_ADDR = CFG_AW'(2 * TBL_DEPTH);

  typedef enum logic [1:0] {
    CFG_NONE  = 2'd0,
    CFG_NET   = 2'd1,
    CFG_HOST  = 2'd2,
    CFG_LOCAL = 2'd3
  } cfg_target_e;

  function automatic cfg_target_e cfg_decode(input logic [CFG_AW-1:0] a);
    cfg_target_e t;
    if (a == LOCAL_REG_ADDR)      t = CFG_LOCAL;
    else if (a[CFG_AW-1:FIELD_W] == '0) t = CFG_NET;
    else if (a[CFG_AW-1:FIELD_W] == 2'd1) t = CFG_HOST;
    else                          t = CFG_NONE;
    return t;
  endfunction

endpackage

// File: rtl/sw_route_tables.sv
module sw_route_tables
  import sw_pkg::*;
#(
  parameter int N_IN   = 2,
  parameter int N_OUT  = 2,
  parameter int DATA_W = 64,
  parameter int PW     = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [CFG_DW-1:0]        cfg_wdata,
  input  logic [N_IN*DATA_W-1:0]   in_data,
  output logic [N_IN*PW-1:0]       look_port
);

  logic [PW-1:0]      net_tbl  [TBL_DEPTH];
  logic [PW-1:0]      host_tbl [TBL_DEPTH];
  logic [FIELD_W-1:0] local_net;
  cfg_target_e        tgt;

  assign tgt = cfg_decode(cfg_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TBL_DEPTH; k++) begin
        net_tbl[k]  <= '0;
        host_tbl[k] <= '0;
      end
      local_net <= '0;
    end else if (cfg_wr) begin
      case (tgt)
        CFG_NET:   net_tbl[cfg_addr[FIELD_W-1:0]]  <= cfg_wdata[PW-1:0];
        CFG_HOST:  host_tbl[cfg_addr[FIELD_W-1:0]] <= cfg_wdata[PW-1:0];
        CFG_LOCAL: local_net <= cfg_wdata[FIELD_W-1:0];
        default:   ;
      endcase
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_look
    logic [SID_W-1:0]   sid;
    logic [FIELD_W-1:0] dnet;
    logic [FIELD_W-1:0] dhost;
    logic [PW-1:0]      raw;

    assign sid   = in_data[i*DATA_W +: SID_W];
    assign dnet  = sid[DNET_LSB  +: FIELD_W];
    assign dhost = sid[DHOST_LSB +: FIELD_W];
    assign raw   = (dnet == local_net) ? host_tbl[dhost] : net_tbl[dnet];

    if ((1 << PW) == N_OUT) begin : g_pow2
      assign look_port[i*PW +: PW] = raw;
    end else begin : g_clamp
      assign look_port[i*PW +: PW] = (32'(raw) < N_OUT) ? raw : '0;
    end
  end

endmodule

// File: rtl/sw_ingress.sv
module sw_ingress #(
  parameter int PW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic          ready,
  input  logic          last,
  input  logic [PW-1:0] look_port,
  output logic [PW-1:0] route,
  output logic          locked
);

  logic [PW-1:0] held;

  assign route = locked ? held : look_port;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      held   <= '0;
    end else if (valid && ready && last) begin
      locked <= 1'b0;
    end else if (valid && !locked) begin
      locked <= 1'b1;
      held   <= look_port;
    end
  end

endmodule

// File: rtl/sw_egress_arb.sv
module sw_egress_arb #(
  parameter int N_IN = 2,
  parameter int IW   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] req,
  input  logic            xfer_last,
  output logic            busy,
  output logic [IW-1:0]   owner
);

  logic [IW-1:0] rr_ptr;
  logic [IW-1:0] pick;
  logic          any_req;

  assign any_req = |req;

  always_comb begin
    int idx;
    logic found;
    pick  = rr_ptr;
    found = 1'b0;
    for (int k = 0; k < N_IN; k++) begin
      idx = (int'(rr_ptr) + k) % N_IN;
      if (!found && req[idx]) begin
        pick  = IW'(idx);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      owner  <= '0;
      rr_ptr <= '0;
    end else if (!busy) begin
      if (any_req) begin
        busy   <= 1'b1;
        owner  <= pick;
        rr_ptr <= IW'((int'(pick) + 1) % N_IN);
      end
    end else if (xfer_last) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/pkt_switch.sv
module pkt_switch
  import sw_pkg::*;
#(
  parameter int N_IN   = 2,
  parameter int N_OUT  = 2,
  parameter int DATA_W = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [9:0]               cfg_addr,
  input  logic [31:0]              cfg_wdata,
  input  logic [N_IN-1:0]          in_valid,
  output logic [N_IN-1:0]          in_ready,
  input  logic [N_IN*DATA_W-1:0]   in_data,
  input  logic [N_IN-1:0]          in_last,
  output logic [N_OUT-1:0]         eg_valid,
  input  logic [N_OUT-1:0]         eg_ready,
  output logic [N_OUT*DATA_W-1:0]  eg_data,
  output logic [N_OUT-1:0]         eg_last
);

  localparam int PW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam int IW = (N_IN  > 1) ? $clog2(N_IN)  : 1;

  logic [N_IN*PW-1:0]  look_port;
  logic [N_IN*PW-1:0]  ing_route;
  logic [N_IN-1:0]     ing_locked;
  logic [N_OUT-1:0]    egr_busy;
  logic [N_OUT*IW-1:0] egr_owner;
  logic [N_OUT-1:0]    egr_xfer_last;

  sw_route_tables #(
    .N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W), .PW(PW)
  ) u_tables (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .in_data   (in_data),
    .look_port (look_port)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_ing
    sw_ingress #(.PW(PW)) u_ing (
      .clk       (clk),
      .rst_n     (rst_n),
      .valid     (in_valid[i]),
      .ready     (in_ready[i]),
      .last      (in_last[i]),
      .look_port (look_port[i*PW +: PW]),
      .route     (ing_route[i*PW +: PW]),
      .locked    (ing_locked[i])
    );
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_egr
    logic [N_IN-1:0]   req;
    logic [IW-1:0]     own;

    for (genvar i = 0; i < N_IN; i++) begin : g_req
      assign req[i] = in_valid[i] && (ing_route[i*PW +: PW] == PW'(j));
    end

    sw_egress_arb #(.N_IN(N_IN), .IW(IW)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .xfer_last (egr_xfer_last[j]),
      .busy      (egr_busy[j]),
      .owner     (own)
    );

    assign egr_owner[j*IW +: IW] = own;
    assign eg_valid[j] = egr_busy[j] && in_valid[own];
    assign eg_last[j]  = egr_busy[j] && in_last[own];
    assign eg_data[j*DATA_W +: DATA_W] = in_data[int'(own)*DATA_W +: DATA_W];
    assign egr_xfer_last[j] = eg_valid[j] && eg_ready[j] && eg_last[j];
  end

  always_comb begin
    in_ready = '0;
    for (int i = 0; i < N_IN; i++) begin
      for (int j = 0; j < N_OUT; j++) begin
        if (egr_busy[j] && egr_owner[j*IW +: IW] == IW'(i) && eg_ready[j])
          in_ready[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sw_checks.sv
module sw_checks #(
  parameter int N_IN  = 2,
  parameter int N_OUT = 2,
  parameter int PW    = 1,
  parameter int IW    = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_IN-1:0]     in_valid,
  input logic [N_IN-1:0]     in_ready,
  input logic [N_IN-1:0]     in_last,
  input logic [N_OUT-1:0]    eg_valid,
  input logic [N_OUT-1:0]    eg_ready,
  input logic [N_OUT-1:0]    eg_last,
  input logic [N_OUT-1:0]    busy,
  input logic [N_OUT*IW-1:0] owner,
  input logic [N_IN*PW-1:0]  route,
  input logic [N_IN-1:0]     locked
);

  logic [N_OUT-1:0] owns [N_IN];
  logic [PW-1:0]    owner_route [N_OUT];

  always_comb begin
    for (int i = 0; i < N_IN; i++)
      for (int j = 0; j < N_OUT; j++)
        owns[i][j] = busy[j] && (owner[j*IW +: IW] == IW'(i));
    for (int j = 0; j < N_OUT; j++)
      owner_route[j] = route[int'(owner[j*IW +: IW])*PW +: PW];
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (eg_valid == '0) && (in_ready == '0)); // R4

  for (genvar j = 0; j < N_OUT; j++) begin : g_e
    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy[j] && !(eg_valid[j] && eg_ready[j] && eg_last[j])
      |=> busy[j] && $stable(owner[j*IW +: IW])); // R6
    AST_OWNER_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
      eg_valid[j] |-> owner_route[j] == PW'(j)); // R5
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_i
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(owns[i])); // R6
    AST_READY_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> |owns[i]); // R9
    AST_ROUTE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      locked[i] && !(in_valid[i] && in_ready[i] && in_last[i])
      |=> $stable(route[i*PW +: PW])); // R5
  end

endmodule

bind pkt_switch sw_checks #(
  .N_IN(N_IN), .N_OUT(N_OUT), .PW(PW), .IW(IW)
) u_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last  (in_last),
  .eg_valid (eg_valid),
  .eg_ready (eg_ready),
  .eg_last  (eg_last),
  .busy     (egr_busy),
  .owner    (egr_owner),
  .route    (ing_route),
  .locked   (ing_locked)
);

// File: tb/tb_pkt_switch.sv
module tb_pkt_switch;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 2;
  localparam int NO = 2;
  localparam int DW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [9:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [NI-1:0] in_valid, in_ready, in_last;
  logic [NI*DW-1:0] in_data;
  logic [NO-1:0] eg_valid, eg_ready, eg_last;
  logic [NO*DW-1:0] eg_data;

  logic          sv [NI];
  logic          sl [NI];
  logic [DW-1:0] sd [NI];
  logic          mr [NO];
  int            mr_mode [NO];

  assign in_valid = {sv[1], sv[0]};
  assign in_last  = {sl[1], sl[0]};
  assign in_data  = {sd[1], sd[0]};
  assign eg_ready = {mr[1], mr[0]};

  pkt_switch #(.N_IN(NI), .N_OUT(NO), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .eg_valid(eg_valid),
    .eg_ready(eg_ready), .eg_data(eg_data), .eg_last(eg_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  int b_net [256];
  int b_host [256];
  int b_local;
  logic [DW:0] mq [NI][NO][$];
  int cur_src [NO];
  int cur_dest [NI];
  int last_egr [NI];
  int src_log0 [$];
  bit log_en = 0;
  int seqn [NI];
  int pkts_in = 0;
  int pkts_out = 0;
  int total = 0;
  int fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_port(input logic [31:0] sid);
    int e;
    if (int'(sid[15:8]) == b_local) e = b_host[sid[7:0]];
    else                            e = b_net[sid[15:8]];
    return e & 1;
  endfunction

  always @(posedge clk) begin
    #1;
    for (int j = 0; j < NO; j++)
      mr[j] = (mr_mode[j] == 2) ? (($urandom % 4) != 0) : (mr_mode[j] == 1);
  end

  task automatic cfg_write(input int a, input int d);
    cfg_wr = 1; cfg_addr = 10'(a); cfg_wdata = 32'(d);
    @(posedge clk); #1;
    cfg_wr = 0;
    if (a < 256) b_net[a] = d & 1;
    else if (a < 512) b_host[a-256] = d & 1;
    else if (a == 512) b_local = d & 255;
  endtask

  task automatic send_pkt(input int i, input logic [31:0] sid, input int len);
    int d;
    int s;
    logic [DW-1:0] w;
    s = seqn[i]; seqn[i]++;
    d = exp_port(sid);
    cur_dest[i] = d;
    pkts_in++;
    for (int b = 0; b < len; b++) begin
      if (b == 0) w = {4'(i), 12'(s), 16'h0, sid};
      else        w = {4'(i), 12'(s), 16'(b), 32'hC0DE0000 + 32'(b)};
      mq[i][d].push_back({(b == len-1), w});
    end
    for (int b = 0; b < len; b++) begin
      sv[i] = 1; sl[i] = (b == len-1);
      sd[i] = mq[i][d][mq[i][d].size() - len + b][DW-1:0];
      forever begin
        @(negedge clk);
        if (in_ready[i]) break;
      end
      @(posedge clk); #1;
    end
    sv[i] = 0; sl[i] = 0;
  endtask

  function automatic bit all_empty();
    for (int i = 0; i < NI; i++)
      for (int j = 0; j < NO; j++)
        if (mq[i][j].size() != 0) return 0;
    return 1;
  endfunction

  task automatic drain();
    for (int k = 0; k < 2000 && !all_empty(); k++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic route_check(input int i, input logic [31:0] sid, input int expect_port,
                             input string req);
    send_pkt(i, sid, 2);
    drain();
    chk(last_egr[i] == expect_port, req, "egress for identifier",
        64'(last_egr[i]), 64'(expect_port));
  endtask

  // Monitor: compares every egress beat against the per-pair queues
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int j = 0; j < NO; j++) begin
        if (eg_valid[j] && eg_ready[j]) begin
          logic [DW:0] got;
          got = {eg_last[j], eg_data[j*DW +: DW]};
          if (cur_src[j] < 0) begin
            int src;
            src = -1;
            for (int i = 0; i < NI; i++)
              if (src < 0 && mq[i][j].size() != 0 && mq[i][j][0] == got) src = i;
            chk(src >= 0, "R7", "packet head matches an expected queue front",
                got[63:0], (mq[0][j].size() != 0) ? mq[0][j][0][63:0] : 64'h0);
            if (src >= 0) begin
              void'(mq[src][j].pop_front());
              last_egr[src] = j;
              pkts_out++;
              if (log_en && j == 0) src_log0.push_back(src);
              if (!got[DW]) cur_src[j] = src;
            end
          end else begin
            int s;
            s = cur_src[j];
            chk(mq[s][j].size() != 0 && mq[s][j][0] == got, "R6",
                "continuation beat from same packet", got[63:0],
                (mq[s][j].size() != 0) ? mq[s][j][0][63:0] : 64'h0);
            if (mq[s][j].size() != 0) void'(mq[s][j].pop_front());
            if (got[DW]) cur_src[j] = -1;
          end
        end
      end
      for (int i = 0; i < NI; i++)
        if (sv[i] && in_ready[i])
          chk(mr[cur_dest[i]] && eg_valid[cur_dest[i]], "R9",
              "ingress ready only with its egress moving", 64'(mr[cur_dest[i]]), 64'd1);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) begin b_net[k] = 0; b_host[k] = 0; end
    b_local = 0;
    for (int i = 0; i < NI; i++) begin
      sv[i] = 0; sl[i] = 0; sd[i] = '0; seqn[i] = 0; cur_dest[i] = 0; last_egr[i] = -1;
    end
    for (int j = 0; j < NO; j++) begin mr[j] = 0; mr_mode[j] = 1; cur_src[j] = -1; end

    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(eg_valid == '0, "R4", "egress valid after reset", 64'(eg_valid), 64'd0);
    chk(in_ready == '0, "R4", "ingress ready after reset", 64'(in_ready), 64'd0);
    @(posedge clk); #1;

    // R4: unprogrammed tables send everything to egress 0
    route_check(0, 32'h0000_0201, 0, "R4");
    route_check(1, 32'h0000_0500, 0, "R4");

    // Program tables
    cfg_write(512, 2);
    cfg_write(256 + 1, 1);
    cfg_write(5, 1);
    cfg_write(9, 3);
    cfg_write(10, 2);
    cfg_write(600, 1);
    cfg_write(7, 0);

    // R3: local versus remote selection
    route_check(0, 32'h1234_0201, 1, "R3");
    route_check(0, 32'h1234_0200, 0, "R3");
    route_check(1, 32'h0000_0507, 1, "R3");
    route_check(1, 32'h0000_0701, 0, "R3");
    // R1: only bits 15:0 of the identifier matter
    route_check(0, 32'hFFFF_0500, 1, "R1");
    route_check(1, 32'h0201_0105, 0, "R1");
    // R2: low bit of entries; unmapped address ignored
    route_check(0, 32'h0000_0900, 1, "R2");
    route_check(1, 32'h0000_0A00, 0, "R2");
    route_check(0, 32'h0000_5800, 0, "R2");

    // R5/R9: table write while a packet waits on a stalled egress
    mr_mode[1] = 0;
    fork
      send_pkt(0, 32'h0000_0500, 3);
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_ready[0] == 1'b0, "R9", "stalled ingress ready", 64'(in_ready[0]), 64'd0);
        chk(eg_valid[1] == 1'b1, "R9", "granted egress valid", 64'(eg_valid[1]), 64'd1);
        @(posedge clk); #1;
        cfg_write(5, 0);
        repeat (2) @(posedge clk);
        mr_mode[1] = 1;
      end
    join
    drain();
    chk(last_egr[0] == 1, "R5", "in-flight route kept", 64'(last_egr[0]), 64'd1);
    route_check(0, 32'h0000_0500, 0, "R5");
    cfg_write(5, 1);

    // R8: contention alternates between ingress ports
    log_en = 1;
    fork
      for (int k = 0; k < 4; k++) send_pkt(0, 32'h0000_0000, 2);
      for (int k = 0; k < 4; k++) send_pkt(1, 32'h0000_0200, 3);
    join
    drain();
    log_en = 0;
    chk(src_log0.size() == 8, "R8", "packets logged", 64'(src_log0.size()), 64'd8);
    for (int k = 1; k < src_log0.size(); k++)
      chk(src_log0[k] != src_log0[k-1], "R8", "grant rotates",
          64'(src_log0[k]), 64'(1 - src_log0[k-1]));

    // R6/R7: mixed traffic under random egress stalls
    mr_mode[0] = 2; mr_mode[1] = 2;
    fork
      for (int k = 0; k < 16; k++) begin
        logic [31:0] ids [5] = '{32'h0200, 32'h0201, 32'h0500, 32'h0700, 32'h0900};
        send_pkt(0, ids[$urandom % 5], 1 + ($urandom % 4));
      end
      for (int k = 0; k < 16; k++) begin
        logic [31:0] ids [5] = '{32'h0200, 32'h0201, 32'h0500, 32'h0700, 32'h0900};
        send_pkt(1, ids[$urandom % 5], 1 + ($urandom % 4));
      end
    join
    mr_mode[0] = 1; mr_mode[1] = 1;
    drain();
    chk(all_empty(), "R7", "all expected beats delivered", 64'(all_empty()), 64'd1);
    chk(pkts_out == pkts_in, "R6", "packet count", 64'(pkts_out), 64'(pkts_in));

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule